// File: doc/BRIEF.md
# Line Port Configuration and Loopback Resolver

This block settles the working configuration of a single line port. At reset it captures three-level strap inputs (low, high or left floating) into configuration registers: a rate strap selects E3, DS3 or STS-1, and a jitter filter strap selects whether the filter is off or placed in the receive or transmit path. The filter bandwidth default follows from the captured rate. After reset the straps no longer matter, and a write strobe can overwrite the stored configuration.

Loopback and receiver source selection come either from a three-level loopback pin or from register bits, chosen by a register-control enable. The transmitter is gated by an enable bit and by a three-level build-out pin. The build-out selection is forced off in E3. When remote loopback is active, the receive data is routed back into the transmit data path in place of the framer's transmit data.

Top module: `port_mode_ctl`

## Requirements
- R1: Three-level inputs use the code 00 = low, 01 = high, 10 or 11 = floating. While `rst_n` is low, each clock edge loads the rate bits {rate_ds3, rate_e3} from `mode_strap`: low gives 01 (E3), high gives 10 (DS3), floating gives STS-1, encoded 00 (or 11 when `STS1_CODE_ONES` = 1). After reset, `mode_strap` has no effect.
- R2: While `rst_n` is low, `ja_strap` low gives the filter enabled in the receive path (`ja_en`=1, `ja_tx_path`=0). High gives it enabled in the transmit path (1,1). Floating gives it disabled (0,0). After reset, `ja_strap` has no effect. `ja_tx_path` is 1 only when `ja_en` is 1.
- R3: At reset, `ja_bw` is set to 1 when the strap selects STS-1 and to 0 for E3 or DS3.
- R4: In a clock cycle with `rst_n` high and `cfg_we` high, the rate, filter enable, filter path and bandwidth registers load from the `cfg_*` inputs. Without `cfg_we`, they hold their value.
- R5: With `reg_ctl_en`=0, the loopback pin set low gives `rlb_en`=0 and `rx_src`=00. Floating gives `rlb_en`=1 and `rx_src`=00. High gives `rlb_en`=0 and `rx_src`=01 (own transmitter output).
- R6: With `reg_ctl_en`=1, `rlb_en` follows `reg_rlb` and `rx_src` follows `reg_src`. The codes are 00 own line, 01 own transmitter, 10 neighbour line, 11 neighbour transmitter.
- R7: `rx_src` codes 10 and 11 never appear while `reg_ctl_en`=0.
- R8: `tx_en` is 1 only when `reg_tx_en`=1 and `bo_pin` is not floating. While `tx_en`=0, `tx_pos_out` and `tx_neg_out` are 0.
- R9: `bo_short` is 0 in E3 mode (rate bits 01). In other modes it equals `reg_bo` with `reg_ctl_en`=1, and (`bo_pin` high) with `reg_ctl_en`=0.
- R10: With `tx_en`=1 and `rlb_en`=1, `tx_pos_out`/`tx_neg_out` equal `rx_pos_in`/`rx_neg_in`, and `tx_pos_in`/`tx_neg_in` have no effect. With `rlb_en`=0, they equal `tx_pos_in`/`tx_neg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| mode_strap | input | 2 | Three-level rate strap |
| ja_strap | input | 2 | Three-level jitter filter strap |
| lpbk_pin | input | 2 | Three-level loopback pin |
| bo_pin | input | 2 | Three-level build-out pin |
| reg_ctl_en | input | 1 | 1: registers drive loopback and build-out |
| reg_rlb | input | 1 | Register remote loopback bit |
| reg_src | input | 2 | Register receiver source code |
| reg_bo | input | 1 | Register build-out bit |
| reg_tx_en | input | 1 | Register transmitter enable |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_ds3 | input | 1 | Written DS3 rate bit |
| cfg_e3 | input | 1 | Written E3 rate bit |
| cfg_ja_en | input | 1 | Written filter enable |
| cfg_ja_tx | input | 1 | Written filter path (1 = transmit) |
| cfg_ja_bw | input | 1 | Written bandwidth select |
| tx_pos_in | input | 1 | Framer transmit positive data |
| tx_neg_in | input | 1 | Framer transmit negative data |
| rx_pos_in | input | 1 | Receive positive data |
| rx_neg_in | input | 1 | Receive negative data |
| rate_ds3 | output | 1 | Rate bit DS3 |
| rate_e3 | output | 1 | Rate bit E3 |
| ja_en | output | 1 | Jitter filter enabled |
| ja_tx_path | output | 1 | Filter in transmit path |
| ja_bw | output | 1 | Filter bandwidth select |
| rx_src | output | 2 | Receiver input source code |
| rlb_en | output | 1 | Remote loopback active |
| tx_en | output | 1 | Transmitter enabled |
| bo_short | output | 1 | Short-cable build-out selected |
| tx_pos_out | output | 1 | Transmit positive data to line side |
| tx_neg_out | output | 1 | Transmit negative data to line side |

## Verification
The bench builds two copies of the block: `uut` with default parameters and a second copy with `STS1_CODE_ONES` = 1. The second copy brings the alternate STS-1 rate encoding within reach whenever the rate strap floats at reset. Both copies take every strap pair through reset, covering the 11 code for floating, and then check that moving the straps afterwards changes nothing. Random runs then mix configuration writes, every loopback pin level against register control, and floating build-out pins in E3 and non-E3 modes.

// File: rtl/port_mode_pkg.sv
package port_mode_pkg;

   typedef enum logic [1:0] {
      TL_LOW   = 2'b00,
      TL_HIGH  = 2'b01,
      TL_FLOAT = 2'b10
   } tri_lvl_t;

   typedef struct packed {
      logic ds3;
      logic e3;
      logic ja_en;
      logic ja_tx;
      logic ja_bw;
   } port_cfg_t;

endpackage

// File: rtl/tri_lvl_decode.sv
module tri_lvl_decode #(
   parameter int N_PINS = 4,
   parameter int CODE_W = 2
) (
   input  logic [N_PINS*CODE_W-1:0] raw,
   output logic [N_PINS-1:0]        is_low,
   output logic [N_PINS-1:0]        is_high,
   output logic [N_PINS-1:0]        is_float
);
   import port_mode_pkg::*;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      logic [CODE_W-1:0] code;
      assign code        = raw[i*CODE_W +: CODE_W];
      // any code with the upper bit set reads as floating
      assign is_float[i] = code[CODE_W-1];
      assign is_high[i]  = !code[CODE_W-1] && (code == CODE_W'(TL_HIGH));
      assign is_low[i]   = !code[CODE_W-1] && (code == CODE_W'(TL_LOW));
   end
endmodule

// File: rtl/cfg_strap_regs.sv
module cfg_strap_regs
   import port_mode_pkg::*;
#(
   parameter bit STS1_CODE_ONES = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mode_low,
   input  logic      mode_high,
   input  logic      mode_float,
   input  logic      ja_low,
   input  logic      ja_high,
   input  logic      ja_float,
   input  logic      cfg_we,
   input  port_cfg_t cfg_wdata,
   output port_cfg_t cfg_q
);
   localparam logic [1:0] STS1_RATE = STS1_CODE_ONES ? 2'b11 : 2'b00;

   port_cfg_t strap_dflt;

   always_comb begin
      strap_dflt = '0;
      unique case (1'b1)
         mode_low:  {strap_dflt.ds3, strap_dflt.e3} = 2'b01;
         mode_high: {strap_dflt.ds3, strap_dflt.e3} = 2'b10;
         default:   {strap_dflt.ds3, strap_dflt.e3} = STS1_RATE;
      endcase
      strap_dflt.ja_bw = mode_float;
      strap_dflt.ja_en = ja_low || ja_high;
      strap_dflt.ja_tx = ja_high;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= strap_dflt;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   // R4: without a write the configuration holds
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));
   // R1: low rate strap at reset yields E3
   a_r1_low_e3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n && mode_low) |-> (!cfg_q.ds3 && cfg_q.e3));
   // R2: floating filter strap at reset disables the filter
   a_r2_float_off: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n && ja_float) |-> !cfg_q.ja_en);
   // R3: STS-1 strap sets the wide bandwidth default
   a_r3_sts1_bw: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n && mode_float) |-> cfg_q.ja_bw);
endmodule

// File: rtl/lpbk_resolve.sv
module lpbk_resolve #(
   parameter int SRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_ctl_en,
   input  logic             pin_high,
   input  logic             pin_float,
   input  logic             reg_rlb,
   input  logic [SRC_W-1:0] reg_src,
   output logic             rlb_en,
   output logic [SRC_W-1:0] rx_src
);
   localparam logic [SRC_W-1:0] SRC_OWN_LINE = '0;
   localparam logic [SRC_W-1:0] SRC_OWN_TX   = SRC_W'(1);

   always_comb begin
      if (reg_ctl_en) begin
         rlb_en = reg_rlb;
         rx_src = reg_src;
      end else begin
         rlb_en = pin_float;
         rx_src = pin_high ? SRC_OWN_TX : SRC_OWN_LINE;
      end
   end

   // R7: neighbour sources never reachable from the pin
   a_r7_pin_no_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_ctl_en |-> !rx_src[SRC_W-1]);
   // R5: floating pin means remote loopback on own line
   a_r5_float_remote: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_ctl_en && pin_float) |-> (rlb_en && rx_src == SRC_OWN_LINE));
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic e3_mode,
   input  logic reg_ctl_en,
   input  logic reg_bo,
   input  logic bo_high,
   input  logic bo_float,
   input  logic reg_tx_en,
   input  logic rlb_en,
   input  logic tx_pos_in,
   input  logic tx_neg_in,
   input  logic rx_pos_in,
   input  logic rx_neg_in,
   output logic tx_en,
   output logic bo_short,
   output logic tx_pos_out,
   output logic tx_neg_out
);
   logic bo_sel;
   logic pos_mux, neg_mux;

   assign tx_en    = reg_tx_en && !bo_float;
   assign bo_sel   = reg_ctl_en ? reg_bo : bo_high;
   assign bo_short = bo_sel && !e3_mode;

   assign pos_mux    = rlb_en ? rx_pos_in : tx_pos_in;
   assign neg_mux    = rlb_en ? rx_neg_in : tx_neg_in;
   assign tx_pos_out = tx_en && pos_mux;
   assign tx_neg_out = tx_en && neg_mux;

   // R8: floating build-out pin silences the transmitter
   a_r8_float_bo_off: assert property (@(posedge clk) disable iff (!rst_n)
      bo_float |-> (!tx_en && !tx_pos_out && !tx_neg_out));
   // R9: build-out never asserted in E3
   a_r9_e3_no_bo: assert property (@(posedge clk) disable iff (!rst_n)
      e3_mode |-> !bo_short);
   // R10: remote loopback carries receive data to the line side
   a_r10_loop_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rlb_en && tx_en) |-> (tx_pos_out == rx_pos_in && tx_neg_out == rx_neg_in));
endmodule

// File: rtl/port_mode_ctl.sv
module port_mode_ctl
   import port_mode_pkg::*;
#(
   parameter int SRC_W          = 2,
   parameter int CODE_W         = 2,
   parameter bit STS1_CODE_ONES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] mode_strap,
   input  logic [CODE_W-1:0] ja_strap,
   input  logic [CODE_W-1:0] lpbk_pin,
   input  logic [CODE_W-1:0] bo_pin,
   input  logic              reg_ctl_en,
   input  logic              reg_rlb,
   input  logic [SRC_W-1:0]  reg_src,
   input  logic              reg_bo,
   input  logic              reg_tx_en,
   input  logic              cfg_we,
   input  logic              cfg_ds3,
   input  logic              cfg_e3,
   input  logic              cfg_ja_en,
   input  logic              cfg_ja_tx,
   input  logic              cfg_ja_bw,
   input  logic              tx_pos_in,
   input  logic              tx_neg_in,
   input  logic              rx_pos_in,
   input  logic              rx_neg_in,
   output logic              rate_ds3,
   output logic              rate_e3,
   output logic              ja_en,
   output logic              ja_tx_path,
   output logic              ja_bw,
   output logic [SRC_W-1:0]  rx_src,
   output logic              rlb_en,
   output logic              tx_en,
   output logic              bo_short,
   output logic              tx_pos_out,
   output logic              tx_neg_out
);
   localparam int N_TRI   = 4;
   localparam int I_MODE  = 0;
   localparam int I_JA    = 1;
   localparam int I_LPBK  = 2;
   localparam int I_BO    = 3;

   if (SRC_W != 2) begin : g_bad_src_w
      $error("port_mode_ctl: SRC_W must be 2 (four receiver sources)");
   end
   if (CODE_W != 2) begin : g_bad_code_w
      $error("port_mode_ctl: CODE_W must be 2 for three-level codes");
   end

   logic [N_TRI-1:0] t_low, t_high, t_float;
   port_cfg_t        cfg_q, cfg_wdata;
   logic             e3_mode;

   tri_lvl_decode #(.N_PINS(N_TRI), .CODE_W(CODE_W)) u_dec (
      .raw      ({bo_pin, lpbk_pin, ja_strap, mode_strap}),
      .is_low   (t_low),
      .is_high  (t_high),
      .is_float (t_float)
   );

   assign cfg_wdata = '{ds3: cfg_ds3, e3: cfg_e3, ja_en: cfg_ja_en,
                        ja_tx: cfg_ja_tx, ja_bw: cfg_ja_bw};

   cfg_strap_regs #(.STS1_CODE_ONES(STS1_CODE_ONES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_low   (t_low[I_MODE]),
      .mode_high  (t_high[I_MODE]),
      .mode_float (t_float[I_MODE]),
      .ja_low     (t_low[I_JA]),
      .ja_high    (t_high[I_JA]),
      .ja_float   (t_float[I_JA]),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_q      (cfg_q)
   );

   assign rate_ds3   = cfg_q.ds3;
   assign rate_e3    = cfg_q.e3;
   assign ja_en      = cfg_q.ja_en;
   assign ja_tx_path = cfg_q.ja_en && cfg_q.ja_tx;
   assign ja_bw      = cfg_q.ja_bw;
   assign e3_mode    = cfg_q.e3 && !cfg_q.ds3;

   lpbk_resolve #(.SRC_W(SRC_W)) u_lpbk (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_ctl_en (reg_ctl_en),
      .pin_high   (t_high[I_LPBK]),
      .pin_float  (t_float[I_LPBK]),
      .reg_rlb    (reg_rlb),
      .reg_src    (reg_src),
      .rlb_en     (rlb_en),
      .rx_src     (rx_src)
   );

   tx_gate u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .e3_mode    (e3_mode),
      .reg_ctl_en (reg_ctl_en),
      .reg_bo     (reg_bo),
      .bo_high    (t_high[I_BO]),
      .bo_float   (t_float[I_BO]),
      .reg_tx_en  (reg_tx_en),
      .rlb_en     (rlb_en),
      .tx_pos_in  (tx_pos_in),
      .tx_neg_in  (tx_neg_in),
      .rx_pos_in  (rx_pos_in),
      .rx_neg_in  (rx_neg_in),
      .tx_en      (tx_en),
      .bo_short   (bo_short),
      .tx_pos_out (tx_pos_out),
      .tx_neg_out (tx_neg_out)
   );

   // R2: transmit path only reported while the filter is enabled
   a_r2_path_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ja_tx_path |-> ja_en);
endmodule

// File: tb/port_mode_ctl_test.sv
`timescale 1ns/1ps
module port_mode_ctl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_strap = '0, ja_strap = '0, lpbk_pin = '0, bo_pin = '0;
   logic reg_ctl_en = 0, reg_rlb = 0, reg_bo = 0, reg_tx_en = 0;
   logic [1:0] reg_src = '0;
   logic cfg_we = 0, cfg_ds3 = 0, cfg_e3 = 0, cfg_ja_en = 0, cfg_ja_tx = 0, cfg_ja_bw = 0;
   logic tx_pos_in = 0, tx_neg_in = 0, rx_pos_in = 0, rx_neg_in = 0;

   logic rate_ds3, rate_e3, ja_en, ja_tx_path, ja_bw, rlb_en, tx_en, bo_short, tx_pos_out, tx_neg_out;
   logic [1:0] rx_src;
   logic a_ds3, a_e3, a_ja_en, a_ja_tx, a_ja_bw, a_rlb, a_tx_en, a_bo, a_tp, a_tn;
   logic [1:0] a_src;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   // model state: {ds3,e3}, en, tx, bw
   logic [1:0] m_rate;
   logic m_en, m_tx, m_bw;

   always #4 clk = ~clk;

   port_mode_ctl uut (
      .clk, .rst_n, .mode_strap, .ja_strap, .lpbk_pin, .bo_pin, .reg_ctl_en, .reg_rlb,
      .reg_src, .reg_bo, .reg_tx_en, .cfg_we, .cfg_ds3, .cfg_e3, .cfg_ja_en, .cfg_ja_tx,
      .cfg_ja_bw, .tx_pos_in, .tx_neg_in, .rx_pos_in, .rx_neg_in, .rate_ds3, .rate_e3,
      .ja_en, .ja_tx_path, .ja_bw, .rx_src, .rlb_en, .tx_en, .bo_short, .tx_pos_out, .tx_neg_out);

   port_mode_ctl #(.STS1_CODE_ONES(1'b1)) uut_alt (
      .clk, .rst_n, .mode_strap, .ja_strap, .lpbk_pin, .bo_pin, .reg_ctl_en, .reg_rlb,
      .reg_src, .reg_bo, .reg_tx_en, .cfg_we, .cfg_ds3, .cfg_e3, .cfg_ja_en, .cfg_ja_tx,
      .cfg_ja_bw, .tx_pos_in, .tx_neg_in, .rx_pos_in, .rx_neg_in,
      .rate_ds3(a_ds3), .rate_e3(a_e3), .ja_en(a_ja_en), .ja_tx_path(a_ja_tx), .ja_bw(a_ja_bw),
      .rx_src(a_src), .rlb_en(a_rlb), .tx_en(a_tx_en), .bo_short(a_bo),
      .tx_pos_out(a_tp), .tx_neg_out(a_tn));

   function automatic logic [1:0] exp_rate(logic [1:0] s, bit ones);
      if (s == 2'b00) return 2'b01;
      if (s == 2'b01) return 2'b10;
      return ones ? 2'b11 : 2'b00;
   endfunction

   function automatic logic [1:0] exp_ja(logic [1:0] s); // {en, tx}
      if (s == 2'b00) return 2'b10;
      if (s == 2'b01) return 2'b11;
      return 2'b00;
   endfunction

   task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      logic e3m, rlb_e, te;
      logic [1:0] src_e;
      logic bo_e, tp_e, tn_e;
      e3m   = (m_rate == 2'b01);
      rlb_e = reg_ctl_en ? reg_rlb : lpbk_pin[1];
      src_e = reg_ctl_en ? reg_src : ((lpbk_pin == 2'b01) ? 2'b01 : 2'b00);
      te    = reg_tx_en && !bo_pin[1];
      bo_e  = e3m ? 1'b0 : (reg_ctl_en ? reg_bo : (bo_pin == 2'b01));
      tp_e  = te && (rlb_e ? rx_pos_in : tx_pos_in);
      tn_e  = te && (rlb_e ? rx_neg_in : tx_neg_in);
      chk("R4", "rate", {2'b0, rate_ds3, rate_e3}, {2'b0, m_rate});
      chk("R4", "ja", {1'b0, ja_en, ja_tx_path, ja_bw}, {1'b0, m_en, m_en && m_tx, m_bw});
      chk(reg_ctl_en ? "R6" : "R5", "rlb", {3'b0, rlb_en}, {3'b0, rlb_e});
      chk(reg_ctl_en ? "R6" : "R7", "src", {2'b0, rx_src}, {2'b0, src_e});
      chk("R8", "tx_en", {3'b0, tx_en}, {3'b0, te});
      chk("R9", "bo_short", {3'b0, bo_short}, {3'b0, bo_e});
      chk("R10", "tx data", {2'b0, tx_pos_out, tx_neg_out}, {2'b0, tp_e, tn_e});
   endtask

   // drive at the falling edge, settle, compare, then account for the next rising edge
   task automatic step();
      #1;
      check_all();
      if (cfg_we) begin
         m_rate = {cfg_ds3, cfg_e3};
         {m_en, m_tx, m_bw} = {cfg_ja_en, cfg_ja_tx, cfg_ja_bw};
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_2344));
      @(negedge clk);
      // strap capture through reset, every code pair
      for (int ms = 0; ms < 4; ms++) begin
         for (int js = 0; js < 4; js++) begin
            rst_n = 0; cfg_we = 0;
            mode_strap = 2'(ms); ja_strap = 2'(js);
            @(negedge clk); @(negedge clk);
            rst_n = 1;
            #1;
            chk("R1", "rate at reset", {2'b0, rate_ds3, rate_e3}, {2'b0, exp_rate(2'(ms), 0)});
            chk("R1", "alt rate at reset", {2'b0, a_ds3, a_e3}, {2'b0, exp_rate(2'(ms), 1)});
            chk("R2", "ja at reset", {2'b0, ja_en, ja_tx_path}, {2'b0, exp_ja(2'(js))});
            chk("R3", "bw at reset", {3'b0, ja_bw}, {3'b0, ms[1]});
            // straps move after reset: no effect
            mode_strap = 2'(ms + 1); ja_strap = 2'(js + 2);
            @(negedge clk); @(negedge clk);
            #1;
            chk("R1", "rate after strap move", {2'b0, rate_ds3, rate_e3}, {2'b0, exp_rate(2'(ms), 0)});
            chk("R2", "ja after strap move", {2'b0, ja_en, ja_tx_path}, {2'b0, exp_ja(2'(js))});
            @(negedge clk);
         end
      end
      // model starts from last reset (mode 3, ja 3)
      m_rate = 2'b00; m_en = 0; m_tx = 0; m_bw = 1;
      // directed: pin-controlled loopback and register neighbour codes
      reg_tx_en = 1; bo_pin = 2'b00; reg_ctl_en = 0;
      tx_pos_in = 1; tx_neg_in = 0; rx_pos_in = 0; rx_neg_in = 1;
      lpbk_pin = 2'b00; step();
      lpbk_pin = 2'b01; step();
      lpbk_pin = 2'b10; step();
      lpbk_pin = 2'b11; step();
      reg_ctl_en = 1; reg_src = 2'b10; reg_rlb = 0; step();
      reg_src = 2'b11; reg_rlb = 1; step();
      // directed: E3 mode ignores build-out; floating build-out pin gates transmitter
      cfg_we = 1; {cfg_ds3, cfg_e3} = 2'b01; step();
      cfg_we = 0; reg_bo = 1; bo_pin = 2'b01; step();
      reg_ctl_en = 0; step();
      bo_pin = 2'b10; step();
      // random mix
      for (int i = 0; i < 600; i++) begin
         mode_strap = 2'($urandom); ja_strap = 2'($urandom);
         lpbk_pin = 2'($urandom); bo_pin = 2'($urandom);
         reg_ctl_en = 1'($urandom); reg_rlb = 1'($urandom); reg_src = 2'($urandom);
         reg_bo = 1'($urandom); reg_tx_en = ($urandom % 4) != 0;
         cfg_we = ($urandom % 8) == 0;
         {cfg_ds3, cfg_e3, cfg_ja_en, cfg_ja_tx, cfg_ja_bw} = 5'($urandom);
         {tx_pos_in, tx_neg_in, rx_pos_in, rx_neg_in} = 4'($urandom);
         step();
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule